// File: doc/BRIEF.md
# Two-Tone FSK Demodulator with Counting Filter

This block turns a digitized two-tone FSK square wave into a one-bit data stream. The tones sit near 5 kHz and 10 kHz. The input is one bit wide and arrives synchronous to the system clock. It first passes through a two-flop synchronizer. It is then compared with a copy of itself that is held back by a fixed number of clock cycles. The exclusive-OR of the two copies is a pulse train whose duty cycle depends on the tone. With the default delay of 37.5 µs, the duty is about 37.5 % on the low tone and about 75 % on the high tone.

A saturating up/down counter stands in for an analog RC low-pass filter. It looks at the pulse train once on every sample tick, which defaults to once per 20 µs. It moves one step up when the pulse train is high and one step down when it is low, and it stays within 0 to 32. A threshold at 16, with optional hysteresis, turns the counter level into the data bit. The data bit can feed a UART receiver directly. The counter level is also brought out, so that the filter state can be observed.

Top module: `fsk_delay_demod`

## Requirements
- R1: While reset is high, and on the first clock after it, `data_out` is 0 and `level` is 0. Reset is synchronous and active high, and it also clears the delay line.
- R2: The correlation bit is the synchronized input XOR the synchronized input delayed by D cycles, where D = DELAY_NS·CLK_HZ/1e9, rounded down. If the input toggles every D cycles, the level rises. If the input is held constant, the level falls.
- R3: `level` changes only on a sample tick. Ticks come every CLK_HZ·TICK_US/1e6 cycles, so while the level climbs steadily, successive changes are exactly that many cycles apart.
- R4: On a tick with the correlation bit at 1, the level rises by one. At 32 it stays at 32.
- R5: On a tick with the correlation bit at 0, the level falls by one. At 0 it stays at 0.
- R6: With HYST = 0, `data_out` is set one cycle after `level` is above 16 and cleared one cycle after `level` is below 16. A level of exactly 16 keeps the previous value.
- R7: With HYST = H > 0, `data_out` rises only one cycle after `level` ≥ 16+H and falls only one cycle after `level` ≤ 16−H. Between those values it holds.
- R8: A sustained 10 kHz tone gives `data_out` = 1 with `level` ≥ 24. A sustained 5 kHz tone gives `data_out` = 0 with `level` ≤ 8.
- R9: `level` never exceeds 32 and moves by at most 1 per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fsk_in | input | 1 | Digitized FSK square wave |
| data_out | output | 1 | Recovered data bit |
| level | output | 6 | Current counting-filter level, 0 to 32 |

## Verification
The in-RTL properties check several rules on every cycle:
- the bounds on the level and its single-step motion;
- that the level stays frozen between ticks;
- saturation at both ends of the range;
- the mapping from level to output, including the hold band.

Other behaviour shows only under the bench's scenarios:
- the exact tick spacing;
- that a toggle at the delay period keeps the correlation bit high;
- the exact levels at which the output switches with and without hysteresis;
- that real 5 kHz and 10 kHz tones settle on the correct bit.

// File: rtl/fskd_pkg.sv
package fskd_pkg;

    localparam int LVL_MAX = 32;
    localparam int LVL_MID = 16;
    localparam int LVL_W   = $clog2(LVL_MAX + 1);

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        DEC_HOLD = 2'd0,
        DEC_SET  = 2'd1,
        DEC_CLR  = 2'd2
    } dec_e;

    function automatic int ns_to_cycles(input int clk_hz, input int ns);
        return (clk_hz / 1000) * ns / 1000000;
    endfunction

    function automatic lvl_t sat_step(input lvl_t cur, input logic up);
        if (up)
            return (cur < lvl_t'(LVL_MAX)) ? cur + lvl_t'(1) : cur;
        else
            return (cur != '0) ? cur - lvl_t'(1) : cur;
    endfunction

endpackage

// File: rtl/fskd_correlator.sv
module fskd_correlator #(
    parameter int DELAY = 1875
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic corr
);
    logic s1, s2;
    logic delayed;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= din;
            s2 <= s1;
        end
    end

    generate
        if (DELAY <= 1) begin : g_short
            logic tap;
            always_ff @(posedge clk) begin
                if (rst) tap <= 1'b0;
                else     tap <= s2;
            end
            assign delayed = tap;
        end else begin : g_line
            logic [DELAY-1:0] line;
            always_ff @(posedge clk) begin
                if (rst) line <= '0;
                else     line <= {line[DELAY-2:0], s2};
            end
            assign delayed = line[DELAY-1];
        end
    endgenerate

    assign corr = s2 ^ delayed;

endmodule

// File: rtl/fskd_tick.sv
module fskd_tick #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/fskd_counter.sv
module fskd_counter
    import fskd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic corr,
    output lvl_t lvl
);
    always_ff @(posedge clk) begin
        if (rst)       lvl <= '0;
        else if (tick) lvl <= sat_step(lvl, corr);
    end

    p_range_r9: assert property (@(posedge clk) disable iff (rst)
        lvl <= lvl_t'(LVL_MAX));

    p_step_r9: assert property (@(posedge clk) disable iff (rst)
        (lvl == $past(lvl)) || (lvl == $past(lvl) + lvl_t'(1)) || (lvl + lvl_t'(1) == $past(lvl)));

    p_no_move_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(lvl));

    p_sat_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && corr && lvl == lvl_t'(LVL_MAX)) |=> lvl == lvl_t'(LVL_MAX));

    p_sat_lo_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !corr && lvl == '0) |=> lvl == '0);

endmodule

// File: rtl/fskd_decide.sv
module fskd_decide
    import fskd_pkg::*;
#(
    parameter int HYST = 0
) (
    input  logic clk,
    input  logic rst,
    input  lvl_t lvl,
    output logic bit_out
);
    localparam int   STEP = (HYST == 0) ? 1 : HYST;
    localparam lvl_t HI   = lvl_t'(LVL_MID + STEP);
    localparam lvl_t LO   = lvl_t'(LVL_MID - STEP);

    dec_e dec;

    always_comb begin
        if (lvl >= HI)      dec = DEC_SET;
        else if (lvl <= LO) dec = DEC_CLR;
        else                dec = DEC_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) bit_out <= 1'b0;
        else begin
            case (dec)
                DEC_SET:  bit_out <= 1'b1;
                DEC_CLR:  bit_out <= 1'b0;
                default:  bit_out <= bit_out;
            endcase
        end
    end

    p_set_r6_r7: assert property (@(posedge clk) disable iff (rst)
        (lvl >= HI) |=> bit_out);

    p_clr_r6_r7: assert property (@(posedge clk) disable iff (rst)
        (lvl <= LO) |=> !bit_out);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (lvl > LO && lvl < HI) |=> $stable(bit_out));

endmodule

// File: rtl/fsk_delay_demod.sv
module fsk_delay_demod
    import fskd_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int TICK_US  = 20,
    parameter int DELAY_NS = 37_500,
    parameter int HYST     = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fsk_in,
    output logic             data_out,
    output logic [LVL_W-1:0] level
);
    localparam int DIV   = (CLK_HZ / 1_000_000) * TICK_US;
    localparam int DELAY = ns_to_cycles(CLK_HZ, DELAY_NS);

    logic corr;
    logic tick;
    lvl_t lvl;

    fskd_correlator #(.DELAY(DELAY)) u_corr (
        .clk (clk),
        .rst (rst),
        .din (fsk_in),
        .corr(corr)
    );

    fskd_tick #(.DIV(DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    fskd_counter u_cnt (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .corr(corr),
        .lvl (lvl)
    );

    fskd_decide #(.HYST(HYST)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .lvl    (lvl),
        .bit_out(data_out)
    );

    assign level = lvl;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (level == '0) && !data_out);

endmodule

// File: tb/fsk_delay_demod_tb.sv
module fsk_delay_demod_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_000_000;
    localparam int DLY        = 37;
    localparam int DIVC       = 20;
    localparam int HV         = 4;

    typedef struct packed {
        logic [15:0] half;
        logic [15:0] periods;
        logic        exp_out;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{16'd50,  16'd60, 1'b1},
        '{16'd100, 16'd30, 1'b0},
        '{16'd50,  16'd60, 1'b1},
        '{16'd100, 16'd30, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsk_in = 1'b0;
    logic d0, d1;
    logic [5:0] l0, l1;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_delay_demod #(.CLK_HZ(CLK_HZ), .HYST(0)) u_dut (
        .clk(clk), .rst(rst), .fsk_in(fsk_in), .data_out(d0), .level(l0));

    fsk_delay_demod #(.CLK_HZ(CLK_HZ), .HYST(HV)) u_dut_h (
        .clk(clk), .rst(rst), .fsk_in(fsk_in), .data_out(d1), .level(l1));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // running monitor: decision rule (R6, R7), level bounds (R9), tick spacing (R3)
    logic e0, e1, ld0, ld1, have;
    logic [5:0] pl0, pl1;
    int gap, last_gap, rise0, rise1, fall0, fall1;

    always @(negedge clk) begin
        if (rst) begin
            e0 = 0; e1 = 0; have = 0; gap = 0;
        end else begin
            if (have) begin
                if (pl0 > 16) e0 = 1; else if (pl0 < 16) e0 = 0;
                if (pl1 >= 16 + HV) e1 = 1; else if (pl1 <= 16 - HV) e1 = 0;
                check(d0 == e0, "R6", d0, e0);
                check(d1 == e1, "R7", d1, e1);
                check(l0 <= 32 && (l0 == pl0 || l0 == pl0 + 1 || l0 + 1 == pl0), "R9", l0, pl0);
                gap++;
                if (l0 != pl0) begin last_gap = gap; gap = 0; end
                if (d0 && !ld0) rise0 = l0;
                if (!d0 && ld0) fall0 = l0;
                if (d1 && !ld1) rise1 = l1;
                if (!d1 && ld1) fall1 = l1;
            end
            pl0 = l0; pl1 = l1; ld0 = d0; ld1 = d1; have = 1;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        check(l0 == 0, "R1", l0, 0);
        check(d0 == 0, "R1", d0, 0);
        rst = 1'b0;
        @(negedge clk);
        check(l0 == 0 && l1 == 0, "R1", l0, 0);
        check(d0 == 0 && d1 == 0, "R1", d0, 0);
    endtask

    task automatic tone(input int half, input int periods);
        for (int p = 0; p < periods; p++) begin
            fsk_in = 1'b1; repeat (half) @(negedge clk);
            fsk_in = 1'b0; repeat (half) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();

        // toggle every DLY cycles keeps correlation high: R2, R4
        rise0 = -1; rise1 = -1;
        for (int k = 0; k < 24; k++) begin
            fsk_in = ~fsk_in; repeat (DLY) @(negedge clk);
        end
        check(l0 == 32, "R4", l0, 32);
        check(l0 == l1, "R2", l1, l0);
        check(last_gap == DIVC, "R3", last_gap, DIVC);
        check(rise0 == 17, "R6", rise0, 17);
        check(rise1 == 16 + HV, "R7", rise1, 16 + HV);

        // constant input: correlation low: R2, R5
        fall0 = -1; fall1 = -1;
        repeat (1000) @(negedge clk);
        check(l0 == 0, "R5", l0, 0);
        check(fall0 == 15, "R6", fall0, 15);
        check(fall1 == 16 - HV, "R7", fall1, 16 - HV);
        check(d0 == 0 && d1 == 0, "R5", d0, 0);

        // tone table: R8
        for (int v = 0; v < 4; v++) begin
            tone(int'(VEC[v].half), int'(VEC[v].periods));
            check(d0 == VEC[v].exp_out, "R8", d0, VEC[v].exp_out);
            check(d1 == VEC[v].exp_out, "R8", d1, VEC[v].exp_out);
            if (VEC[v].exp_out) check(l0 >= 24, "R8", l0, 24);
            else                check(l0 <= 8,  "R8", l0, 8);
        end

        // reset while level is high: R1
        tone(50, 30);
        check(l0 > 16, "R8", l0, 17);
        do_reset();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule